// File: doc/BRIEF.md
# Conditional trap comparator

This block decides whether a conditional trap instruction fires. It takes two operands, a 5-bit condition mask and a width mode. Each mask bit enables one relation between the operands: signed less-than, signed greater-than, equality, unsigned less-than or unsigned greater-than. The trap is raised when at least one enabled relation holds.

In word mode only the low 32 bits of each operand are compared. In doubleword mode the full 64-bit operands are compared. A valid strobe goes with each evaluation. One clock later the block presents a registered result: a valid flag, a trap flag, and a cause code that marks the trap as a program exception of the trap kind. The exception pipeline that consumes the result is outside this block.

Top module: `trap_cond_unit`

## Requirements
- R1: While reset is asserted and after its release, before any strobe, `out_valid`, `trap_req` and `trap_cause` are all zero.
- R2: Mask bit 4 (value 0x10) traps when A is less than B as signed numbers.
- R3: Mask bit 3 (value 0x08) traps when A is greater than B as signed numbers.
- R4: Mask bit 2 (value 0x04) traps when A equals B.
- R5: Mask bit 1 (value 0x02) traps when A is less than B as unsigned numbers.
- R6: Mask bit 0 (value 0x01) traps when A is greater than B as unsigned numbers.
- R7: With `dword_mode` = 0, only bits 31:0 of each operand are compared, as 32-bit signed or unsigned values. Bits 63:32 have no effect.
- R8: With `dword_mode` = 1, all 64 bits of each operand are compared.
- R9: The trap fires on the OR of every enabled relation. A relation whose mask bit is clear never causes a trap.
- R10: A mask of 0x00 never traps. A mask of 0x1F always traps.
- R11: `trap_cause` is 8'h72 when `trap_req` is 1 and 8'h00 otherwise. The upper nibble 7 is the program-exception class and the lower nibble 2 is the trap subtype.
- R12: The result appears exactly one cycle after the `in_valid` strobe, and evaluations may follow on back-to-back cycles. A cycle without a strobe yields `out_valid` = 0 and `trap_req` = 0 on the next cycle, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Evaluation strobe |
| dword_mode | input | 1 | 1 = compare 64-bit operands, 0 = compare low 32 bits |
| cond_mask | input | 5 | Relation enables: bit 4 signed lt, bit 3 signed gt, bit 2 eq, bit 1 unsigned lt, bit 0 unsigned gt |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| trap_req | output | 1 | Trap raised |
| trap_cause | output | 8 | Exception class and subtype of the trap, zero when no trap |

## Verification
The signed and unsigned relations are evaluated side by side in the same cycle, and on some operand pairs they disagree. For A = -5 and B = 3, signed less-than holds while unsigned greater-than also holds. The bench drives such pairs under masks that enable only one relation, then under a mask that enables both kinds, and checks that the trap follows exactly the enabled relations.

The width modes interact in the same way. The bench chooses operands whose high halves reverse the outcome of the low halves, evaluates the same pair in both modes, and checks that only the selected width decides the trap.

// File: rtl/trap_pkg.sv
package trap_pkg;

    // Mask bit positions; the order is part of the instruction encoding.
    localparam int MB_SLT = 4;
    localparam int MB_SGT = 3;
    localparam int MB_EQ  = 2;
    localparam int MB_ULT = 1;
    localparam int MB_UGT = 0;
    localparam int MASK_W = 5;

    localparam int CAUSE_W = 8;
    localparam logic [3:0] CLASS_PROGRAM = 4'h7;
    localparam logic [3:0] SUB_TRAP      = 4'h2;
    localparam logic [CAUSE_W-1:0] CAUSE_TRAP = {CLASS_PROGRAM, SUB_TRAP};

    // Outcome of all five relations for one operand pair.
    typedef struct packed {
        logic s_lt;
        logic s_gt;
        logic eq;
        logic u_lt;
        logic u_gt;
    } rel_t;

    // Registered result.
    typedef struct packed {
        logic               valid;
        logic               trap;
        logic [CAUSE_W-1:0] cause;
    } trap_state_t;

endpackage

// File: rtl/trap_rel_cmp.sv
module trap_rel_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output trap_pkg::rel_t  rel
);
    always_comb begin
        rel.s_lt = $signed(a) < $signed(b);
        rel.s_gt = $signed(a) > $signed(b);
        rel.eq   = (a == b);
        rel.u_lt = a < b;
        rel.u_gt = a > b;
    end
endmodule

// File: rtl/trap_mask_eval.sv
module trap_mask_eval
    import trap_pkg::*;
(
    input  rel_t              rel,
    input  logic [MASK_W-1:0] mask,
    output logic              hit
);
    logic [MASK_W-1:0] rel_vec;

    always_comb begin
        rel_vec         = '0;
        rel_vec[MB_SLT] = rel.s_lt;
        rel_vec[MB_SGT] = rel.s_gt;
        rel_vec[MB_EQ]  = rel.eq;
        rel_vec[MB_ULT] = rel.u_lt;
        rel_vec[MB_UGT] = rel.u_gt;
        hit             = |(rel_vec & mask);
    end
endmodule

// File: rtl/trap_cond_unit.sv
module trap_cond_unit
    import trap_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               dword_mode,
    input  logic [4:0]         cond_mask,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    output logic               out_valid,
    output logic               trap_req,
    output logic [7:0]         trap_cause
);
    rel_t        rel_sel;
    logic        hit;
    trap_state_t st_d, st_q;

    // Comparators: a narrow lane on the low halves and a full lane, picked by mode.
    generate
        if (DATA_W > WORD_W) begin : g_dual
            rel_t rel_w, rel_f;
            trap_rel_cmp #(.W(WORD_W)) u_word (
                .a   (opnd_a[WORD_W-1:0]),
                .b   (opnd_b[WORD_W-1:0]),
                .rel (rel_w)
            );
            trap_rel_cmp #(.W(DATA_W)) u_full (
                .a   (opnd_a),
                .b   (opnd_b),
                .rel (rel_f)
            );
            assign rel_sel = dword_mode ? rel_f : rel_w;
        end else begin : g_single
            rel_t rel_f;
            trap_rel_cmp #(.W(DATA_W)) u_full (
                .a   (opnd_a),
                .b   (opnd_b),
                .rel (rel_f)
            );
            assign rel_sel = rel_f;
        end
    endgenerate

    trap_mask_eval u_mask (
        .rel  (rel_sel),
        .mask (cond_mask),
        .hit  (hit)
    );

    always_comb begin
        st_d       = '0;
        st_d.valid = in_valid;
        st_d.trap  = in_valid & hit;
        st_d.cause = st_d.trap ? CAUSE_TRAP : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign trap_req   = st_q.trap;
    assign trap_cause = st_q.cause;

    // Relations of one kind are mutually exclusive and complete.
    AST_SREL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rel_sel.s_lt, rel_sel.s_gt, rel_sel.eq}) == 1); // R2
    AST_UREL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rel_sel.u_lt, rel_sel.u_gt, rel_sel.eq}) == 1); // R5
    AST_STROBE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !trap_req)); // R12
    AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_mask == 5'h00) |=> !trap_req); // R10
    AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_mask == 5'h1F) |=> trap_req); // R10
    AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_cause == 8'h72)); // R11
    AST_CAUSE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> (trap_cause == 8'h00)); // R11
endmodule

// File: tb/sim_trap_cond_unit.sv
module sim_trap_cond_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dword_mode = 1'b0;
    logic [4:0]  cond_mask = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        out_valid;
    logic        trap_req;
    logic [7:0]  trap_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trap_cond_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dword_mode(dword_mode),
        .cond_mask(cond_mask), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .out_valid(out_valid), .trap_req(trap_req), .trap_cause(trap_cause)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One strobed evaluation; result sampled at the falling edge after the capturing edge.
    task automatic run(string req, bit mode, logic [4:0] m, logic [63:0] a,
                       logic [63:0] b, bit exp_trap);
        @(negedge clk);
        in_valid = 1'b1; dword_mode = mode; cond_mask = m; opnd_a = a; opnd_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
        chk({req, " trap"},  {63'd0, trap_req},  {63'd0, exp_trap});
        chk({req, " cause R11"}, {56'd0, trap_cause}, exp_trap ? 64'h72 : 64'h0);
    endtask

    task automatic t_reset();
        chk("R1 valid", {63'd0, out_valid}, 64'd0);
        chk("R1 trap",  {63'd0, trap_req},  64'd0);
        chk("R1 cause", {56'd0, trap_cause}, 64'd0);
    endtask

    task automatic t_signed_unsigned_conflict();
        run("R2 slt",           1'b1, 5'h10, -64'sd5, 64'd3, 1'b1);
        run("R3 sgt false",     1'b1, 5'h08, -64'sd5, 64'd3, 1'b0);
        run("R5 ult false",     1'b1, 5'h02, -64'sd5, 64'd3, 1'b0);
        run("R6 ugt",           1'b1, 5'h01, -64'sd5, 64'd3, 1'b1);
        run("R9 sgt|ult none",  1'b1, 5'h0A, -64'sd5, 64'd3, 1'b0);
        run("R9 slt|ugt",       1'b1, 5'h11, -64'sd5, 64'd3, 1'b1);
    endtask

    task automatic t_greater();
        run("R3 sgt",       1'b1, 5'h08, 64'd7, 64'd2, 1'b1);
        run("R2 slt false", 1'b1, 5'h10, 64'd7, 64'd2, 1'b0);
        run("R5 ult",       1'b1, 5'h02, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        run("R2 slt vs -1", 1'b1, 5'h10, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    endtask

    task automatic t_equal();
        run("R4 eq",          1'b1, 5'h04, 64'h1234, 64'h1234, 1'b1);
        run("R4 eq masked",   1'b1, 5'h1B, 64'h1234, 64'h1234, 1'b0);
        run("R4 eq false",    1'b1, 5'h04, 64'h1234, 64'h1235, 1'b0);
    endtask

    task automatic t_width();
        run("R7 word eq",   1'b0, 5'h04, 64'h1234_5678_0000_0001, 64'h0000_0000_0000_0001, 1'b1);
        run("R8 dword eq",  1'b1, 5'h04, 64'h1234_5678_0000_0001, 64'h0000_0000_0000_0001, 1'b0);
        run("R7 word slt",  1'b0, 5'h10, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001, 1'b1);
        run("R8 dword slt", 1'b1, 5'h10, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001, 1'b0);
        run("R7 word ugt",  1'b0, 5'h01, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001, 1'b1);
    endtask

    task automatic t_mask_extremes();
        run("R10 zero mask lt",  1'b1, 5'h00, 64'd1, 64'd9, 1'b0);
        run("R10 zero mask eq",  1'b0, 5'h00, 64'd4, 64'd4, 1'b0);
        run("R10 full mask eq",  1'b1, 5'h1F, 64'd4, 64'd4, 1'b1);
        run("R10 full mask neg", 1'b0, 5'h1F, 64'h8000_0000, 64'd5, 1'b1);
    endtask

    task automatic t_strobe();
        // No strobe: outputs stay quiet even with an always-trap mask.
        @(negedge clk);
        in_valid = 1'b0; cond_mask = 5'h1F; opnd_a = 64'd3; opnd_b = 64'd3;
        @(negedge clk);
        chk("R12 idle valid", {63'd0, out_valid}, 64'd0);
        chk("R12 idle trap",  {63'd0, trap_req},  64'd0);
        // Back-to-back evaluations.
        in_valid = 1'b1; dword_mode = 1'b1; cond_mask = 5'h04; opnd_a = 64'd8; opnd_b = 64'd8;
        @(negedge clk);
        chk("R12 b2b first valid", {63'd0, out_valid}, 64'd1);
        chk("R12 b2b first trap",  {63'd0, trap_req},  64'd1);
        opnd_b = 64'd9;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R12 b2b second valid", {63'd0, out_valid}, 64'd1);
        chk("R12 b2b second trap",  {63'd0, trap_req},  64'd0);
        @(negedge clk);
        chk("R12 after b2b valid", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_signed_unsigned_conflict();
        t_greater();
        t_equal();
        t_width();
        t_mask_extremes();
        t_strobe();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule